// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Direction-Tracked Flags

This block carries 32-bit words from a fast producer clock domain to a slower consumer clock domain. It has 256 entries. Each side keeps its own pointer in binary, which addresses the storage, and in Gray code, which is compared against the other side. The two Gray pointers are compared asynchronously. A single direction bit records whether the writer last closed in on the reader or the reader last closed in on the writer. Equal pointers then mean full when that bit is set and empty when it is clear, so neither pointer needs an extra wrap bit.

A flag is raised at once when its condition appears. It is released only after two flops in the owning clock domain have seen the condition clear. The consumer does not request the head word: as soon as empty drops, the word at the read pointer is already on the data output. A read then advances past that word. A write attempted while full, or a read attempted while empty, leaves the queue untouched and raises a one-cycle error pulse in that side's clock.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is asserted and right after it, empty_o is 1, full_o is 0 and both error outputs are 0.
- R2: When empty_o is 0, rdata_o shows the oldest stored word without any read request being made.
- R3: Words leave the queue in the order they were written, with all 32 bits intact.
- R4: The queue holds exactly 256 words. full_o stays 0 after 255 accepted writes into an empty queue and is 1 after the 256th.
- R5: A write while full_o is 1 does not store or move anything. wr_err_o is 1 for exactly the next write-clock cycle.
- R6: A read while empty_o is 1 does not move anything. rd_err_o is 1 for exactly the next read-clock cycle.
- R7: empty_o rises on the read edge that removes the last word, and full_o rises on the write edge that stores the 256th word, with no synchronizer delay.
- R8: After the opposite side frees the condition, empty_o or full_o falls on the second rising edge of its own clock.
- R9: Each pointer changes by at most one Gray-code bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Producer clock |
| rclk_i | input | 1 | Consumer clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_i | input | 1 | Write request, producer domain |
| wdata_i | input | 32 | Word to store |
| rd_en_i | input | 1 | Read request (pop the head), consumer domain |
| rdata_o | output | 32 | Current head word (fall-through) |
| full_o | output | 1 | Queue full, producer domain |
| empty_o | output | 1 | Queue empty, consumer domain |
| wr_err_o | output | 1 | Pulse: a write was refused |
| rd_err_o | output | 1 | Pulse: a read was refused |

## Verification
If the direction bit holds the wrong value, equal pointers are decoded the wrong way. A full queue then reads as empty, or the reverse, on the same edge that makes the pointers meet, and the mismatch shows on the flag during the next sample. A pointer that skips or fails to hold shows up as a wrong head word on rdata_o at the very next pop. It also shows up as a missing or extra word when the queue is drained after a refused write. A synchronizer that is too short or too long moves the release of empty by one consumer cycle, and the bench bounds that window.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  parameter int unsigned DCF_DATA_W = 32;
  parameter int unsigned DCF_ADDR_W = 8;
endpackage

// File: rtl/dcf_ptr.sv
module dcf_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] bin_o,
  output logic [AW-1:0] gray_o
);
  logic [AW-1:0] bin_q, gray_q, bin_nx;

  assign bin_nx = bin_q + {{(AW-1){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign bin_o  = bin_q;
  assign gray_o = gray_q;

  assert_gray_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gray_q ^ $past(gray_q)))
    else $error("gray pointer moved more than one bit");
endmodule

// File: rtl/dcf_dir.sv
module dcf_dir #(
  parameter int unsigned AW = 8
) (
  input  logic          rst_ni,
  input  logic [AW-1:0] wgray_i,
  input  logic [AW-1:0] rgray_i,
  output logic          dir_o
);
  logic set_n, clr_n, dir_q;

  // writer one quadrant behind reader -> heading to full
  assign set_n = ~((wgray_i[AW-1] ^ rgray_i[AW-2]) & ~(wgray_i[AW-2] ^ rgray_i[AW-1]));
  // reader one quadrant behind writer -> heading to empty
  assign clr_n = ~(~(wgray_i[AW-1] ^ rgray_i[AW-2]) & (wgray_i[AW-2] ^ rgray_i[AW-1]));

  always_ff @(negedge rst_ni or negedge clr_n or negedge set_n) begin
    if (!rst_ni)     dir_q <= 1'b0;
    else if (!clr_n) dir_q <= 1'b0;
    else             dir_q <= 1'b1;
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/dcf_flag_sync.sv
module dcf_flag_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_ni,
  output logic flag_o
);
  logic [1:0] stg_q;

  // raise at once, release after two local edges
  always_ff @(posedge clk_i or negedge rst_ni or negedge set_ni) begin
    if (!rst_ni)       stg_q <= {2{RST_VAL}};
    else if (!set_ni)  stg_q <= 2'b11;
    else               stg_q <= {stg_q[0], 1'b0};
  end

  assign flag_o = stg_q[1];
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DW = DCF_DATA_W,
  parameter int unsigned AW = DCF_ADDR_W
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          wr_err_o,
  output logic          rd_err_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wbin, wgray, rbin, rgray;
  logic wr_ok, rd_ok, dir, same, full_n, empty_n;
  logic wr_err_q, rd_err_q;

  assign wr_ok = wr_en_i & ~full_o;
  assign rd_ok = rd_en_i & ~empty_o;

  dcf_ptr #(.AW(AW)) u_wptr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .inc_i(wr_ok), .bin_o(wbin), .gray_o(wgray));
  dcf_ptr #(.AW(AW)) u_rptr (
    .clk_i(rclk_i), .rst_ni(rst_ni), .inc_i(rd_ok), .bin_o(rbin), .gray_o(rgray));

  dcf_dir #(.AW(AW)) u_dir (
    .rst_ni(rst_ni), .wgray_i(wgray), .rgray_i(rgray), .dir_o(dir));

  assign same    = (wgray == rgray);
  assign full_n  = ~(same & dir);
  assign empty_n = ~(same & ~dir);

  dcf_flag_sync #(.RST_VAL(1'b0)) u_full (
    .clk_i(wclk_i), .rst_ni(rst_ni), .set_ni(full_n), .flag_o(full_o));
  dcf_flag_sync #(.RST_VAL(1'b1)) u_empty (
    .clk_i(rclk_i), .rst_ni(rst_ni), .set_ni(empty_n), .flag_o(empty_o));

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem[wbin] <= wdata_i;
  end

  assign rdata_o = mem[rbin];

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) wr_err_q <= 1'b0;
    else         wr_err_q <= wr_en_i & full_o;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rd_err_q <= 1'b0;
    else         rd_err_q <= rd_en_i & empty_o;
  end

  assign wr_err_o = wr_err_q;
  assign rd_err_o = rd_err_q;

  assert_no_overflow_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(wbin))
    else $error("write pointer moved while full");
  assert_wr_err_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> wr_err_o)
    else $error("refused write not flagged");
  assert_no_underflow_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> $stable(rbin))
    else $error("read pointer moved while empty");
  assert_rd_err_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> rd_err_o)
    else $error("refused read not flagged");
  assert_rd_err_pulse_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !(rd_en_i && empty_o) |=> !rd_err_o)
    else $error("read error without refused read");
endmodule

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;
  localparam int WCLK_P = 10;
  localparam int RCLK_P = 26;
  localparam int DEPTH  = 256;
  localparam int NRND   = 300;

  logic wclk_i = 1'b0, rclk_i = 1'b0, rst_ni = 1'b1;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic full_o, empty_o, wr_err_o, rd_err_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] q[$];

  always #(WCLK_P/2) wclk_i = ~wclk_i;
  always #(RCLK_P/2) rclk_i = ~rclk_i;

  dcf_fifo dut (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .full_o(full_o), .empty_o(empty_o), .wr_err_o(wr_err_o), .rd_err_o(rd_err_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    return {i[15:0], ~i[15:0]} ^ 32'h5A3C_0000;
  endfunction

  task automatic push_word(input logic [31:0] d);
    @(negedge wclk_i);
    wr_en_i = 1'b1; wdata_i = d; q.push_back(d);
    @(negedge wclk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge rclk_i);
    chk(empty_o == 1'b1, "R1 empty in reset", {31'd0, empty_o}, 32'd1);
    chk(full_o == 1'b0, "R1 full in reset", {31'd0, full_o}, 32'd0);
    @(negedge wclk_i) rst_ni = 1'b1;
    repeat (2) @(negedge rclk_i);
    chk(empty_o == 1'b1, "R1 empty after reset", {31'd0, empty_o}, 32'd1);
    chk(full_o == 1'b0, "R1 full after reset", {31'd0, full_o}, 32'd0);
    chk(wr_err_o == 1'b0 && rd_err_o == 1'b0, "R1 errors after reset",
        {30'd0, wr_err_o, rd_err_o}, 32'd0);

    // refused read
    @(negedge rclk_i) rd_en_i = 1'b1;
    @(negedge rclk_i) rd_en_i = 1'b0;
    chk(rd_err_o == 1'b1, "R6 read error pulse", {31'd0, rd_err_o}, 32'd1);
    chk(empty_o == 1'b1, "R6 still empty", {31'd0, empty_o}, 32'd1);
    @(negedge rclk_i);
    chk(rd_err_o == 1'b0, "R6 pulse one cycle", {31'd0, rd_err_o}, 32'd0);

    // single word: fall-through and release latency
    push_word(32'hA5A5_0001);
    begin
      int n = 0;
      while (empty_o && n < 10) begin @(negedge rclk_i); n++; end
      chk(n <= 3, "R8 empty release latency", n, 3);
    end
    chk(rdata_o == 32'hA5A5_0001, "R2 head shown without read", rdata_o, 32'hA5A5_0001);
    chk(rdata_o == q[0], "R6 refused read left pointer", rdata_o, q[0]);
    rd_en_i = 1'b1; void'(q.pop_front());
    @(negedge rclk_i) rd_en_i = 1'b0;
    chk(empty_o == 1'b1, "R7 empty on last read edge", {31'd0, empty_o}, 32'd1);

    // fill to capacity
    for (int i = 0; i < DEPTH - 1; i++) begin
      @(negedge wclk_i);
      wr_en_i = 1'b1; wdata_i = (i % 2) ? $urandom : pattern(i); q.push_back(wdata_i);
    end
    @(negedge wclk_i);
    wr_en_i = 1'b0;
    chk(full_o == 1'b0, "R4 not full at 255", {31'd0, full_o}, 32'd0);
    wr_en_i = 1'b1; wdata_i = 32'hFFFF_0256; q.push_back(wdata_i);
    @(negedge wclk_i);
    wr_en_i = 1'b0;
    chk(full_o == 1'b1, "R4 R7 full at 256", {31'd0, full_o}, 32'd1);

    // refused write
    wr_en_i = 1'b1; wdata_i = 32'hDEAD_BEEF;
    @(negedge wclk_i);
    wr_en_i = 1'b0;
    chk(wr_err_o == 1'b1, "R5 write error pulse", {31'd0, wr_err_o}, 32'd1);
    chk(full_o == 1'b1, "R5 still full", {31'd0, full_o}, 32'd1);
    @(negedge wclk_i);
    chk(wr_err_o == 1'b0, "R5 pulse one cycle", {31'd0, wr_err_o}, 32'd0);

    // drain
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge rclk_i);
      rd_en_i = 1'b0;
      chk(!empty_o, "R3 data present during drain", {31'd0, empty_o}, 32'd0);
      chk(rdata_o == q[0], "R3 drain order", rdata_o, q[0]);
      rd_en_i = 1'b1; void'(q.pop_front());
    end
    @(negedge rclk_i) rd_en_i = 1'b0;
    chk(empty_o == 1'b1, "R5 R7 refused word absent, empty", {31'd0, empty_o}, 32'd1);
    repeat (3) @(negedge wclk_i);
    chk(full_o == 1'b0, "R8 full released", {31'd0, full_o}, 32'd0);

    // random concurrent traffic
    fork
      begin
        int sent = 0;
        while (sent < NRND) begin
          @(negedge wclk_i);
          if (!full_o && ($urandom % 3 != 0)) begin
            wr_en_i = 1'b1; wdata_i = $urandom; q.push_back(wdata_i); sent++;
          end else wr_en_i = 1'b0;
        end
        @(negedge wclk_i) wr_en_i = 1'b0;
      end
      begin
        int got = 0;
        while (got < NRND) begin
          @(negedge rclk_i);
          rd_en_i = 1'b0;
          if (!empty_o && ($urandom % 4 != 0)) begin
            chk(rdata_o == q[0], "R3 random order", rdata_o, q[0]);
            rd_en_i = 1'b1; void'(q.pop_front()); got++;
          end
        end
        @(negedge rclk_i) rd_en_i = 1'b0;
      end
    join
    chk(empty_o == 1'b1, "R3 empty after random traffic", {31'd0, empty_o}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(WCLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule